// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host's memory strobes and a byte-wide battery-backed storage array. Three comparators outside the block report supply conditions as digital flags: above the full-operation level (about 4.5 V), above the protect level (about 4.25 V) and above the switchover level (about 3.0 V). The flags are brought into the clock domain through a two-stage synchronizer. The block then drives a write-protect flag, a backup-source select and a ready flag, and it gates every read and write that reaches the array.

On the way down, protection comes on as soon as the supply falls below the protect level. From then on the strobes are ignored and the read bus is released. Below the switchover level the array is moved to the backup source. On the way up, the backup select returns to the external supply above the switchover level. Access is still held off until the supply is back above the full level and has stayed there for a configurable number of clock cycles. A write strobe that is still open when protection comes on is dropped, so the array never takes a partial write. The array itself is a behavioural 8192 x 8 store with no limit on the number of writes.

Top module: `pfwp_supervisor`

## Requirements
- R1: While reset is held, writeProtect is 1, ready is 0, backupSel is 0 and rdDriveEn is 0. Reset puts the control in the protected state.
- R2: Each raw supply flag passes through two synchronizer flops before the control acts on it. A change driven between clock edges first shows on writeProtect just after the third rising edge.
- R3: In normal operation, writeProtect goes to 1 and ready goes to 0 once the synchronized supply is below the protect level. writeProtect and ready are never 1 together.
- R4: While writeProtect is 1, rdDriveEn stays 0 whatever the strobes do, and write strobes leave the array unchanged.
- R5: backupSel is 1 exactly while the synchronized supply is below the switchover level. backupSel is 1 only while writeProtect is 1.
- R6: The supply band between the protect level and the full level has hysteresis. Falling into this band from normal operation keeps access open. Rising into it from protection keeps access closed.
- R7: Once the synchronized supply is at the full level, ready rises after RECOVER_CYCLES further cycles. This is at the (3+RECOVER_CYCLES)-th rising edge after the raw flag change. If the supply leaves the full level during the hold-off, the count restarts from zero.
- R8: A flag combination that is not consistent with itself is read as the lowest level it implies. For example, full=1 with protect=0 reads as below the protect level, and switch=0 reads as below switchover whatever the other flags are.
- R9: In normal operation, a write is a strobe with ceN=0 and weN=0. It commits the last presented address and data on the first clock edge where ceN or weN is high again. A read is ceN=0, oeN=0, weN=1: it drives rdDriveEn=1 and rdData combinationally from the addressed byte, including address 0 and address 8191. Contents survive any sequence of protection, backup and recovery.
- R10: A write strobe that is still open when protection comes on never commits, even after power returns.
- R11: rdDriveEn is 1 only when ceN=0, oeN=0 and weN=1. An active write strobe releases the read bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| supplyOkRaw | input | 1 | Raw flag: supply above the full-operation level |
| supplyProtRaw | input | 1 | Raw flag: supply above the protect level |
| supplySwitchRaw | input | 1 | Raw flag: supply above the backup switchover level |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, meaningful while rdDriveEn is 1 |
| rdDriveEn | output | 1 | Read bus driven; 0 means the bus is at high impedance |
| writeProtect | output | 1 | Protection active, all accesses blocked |
| backupSel | output | 1 | Array powered from the backup source |
| ready | output | 1 | Normal access allowed |

## Verification
The hardest case to reach from the ports is a write strobe caught open at the moment protection arrives. The bench holds ceN and weN low, drops the protect flag under the open strobe and keeps the strobe low until protection is visible. It then closes the strobe, powers back up through the full hold-off and reads the address, which must still hold the older byte. The restart of the hold-off is reached in a similar way. The full flag is pulsed low part way through recovery, and the bench confirms that ready stays low past the original deadline and rises at the new deadline on the exact edge.

// File: rtl/pfwp_pkg.sv
`timescale 1ns/1ps
package pfwp_pkg;

  // Synchronized supply level, lowest first
  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,  // below switchover
    LVL_LOW  = 2'd1,  // switchover .. protect
    LVL_MID  = 2'd2,  // protect .. full
    LVL_FULL = 2'd3   // full operation
  } supplyLevel_t;

  typedef enum logic [1:0] {
    ST_GUARD = 2'd0,  // protected
    ST_HOLD  = 2'd1,  // recovery hold-off
    ST_RUN   = 2'd2   // normal access
  } supState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accessEn;    // reads and write capture allowed
    logic abortWrite;  // discard an open write strobe
  } dpStrobe_t;

endpackage

// File: rtl/pfwp_ctrl.sv
`timescale 1ns/1ps
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int RECOVER_CYCLES = 500000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOkRaw,
  input  logic      supplyProtRaw,
  input  logic      supplySwitchRaw,
  output dpStrobe_t strobe,
  output logic      writeProtect,
  output logic      backupSel,
  output logic      ready
);

  localparam int CNT_W = (RECOVER_CYCLES > 1) ? $clog2(RECOVER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVER_CYCLES - 1);

  logic [2:0]   syncPipe [SYNC_STAGES];
  logic [2:0]   flagsSync;
  supplyLevel_t level;
  supState_t    state, stateNext;
  logic [CNT_W-1:0] holdCnt;

  // flag vector: bit2 full, bit1 protect, bit0 switchover
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= {supplyOkRaw, supplyProtRaw, supplySwitchRaw};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign flagsSync = syncPipe[SYNC_STAGES-1];

  // Inconsistent combinations fall to the lowest implied level
  function automatic supplyLevel_t decodeLevel(input logic [2:0] f);
    if (!f[0]) return LVL_OFF;
    if (!f[1]) return LVL_LOW;
    if (!f[2]) return LVL_MID;
    return LVL_FULL;
  endfunction

  assign level = decodeLevel(flagsSync);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (level == LVL_OFF || level == LVL_LOW) stateNext = ST_GUARD;
      ST_GUARD: if (level == LVL_FULL) stateNext = ST_HOLD;
      ST_HOLD: begin
        if (level != LVL_FULL)       stateNext = ST_GUARD;
        else if (holdCnt == CNT_LAST) stateNext = ST_RUN;
      end
      default:  stateNext = ST_GUARD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_GUARD;
      holdCnt <= '0;
    end else begin
      state <= stateNext;
      if (stateNext == ST_HOLD && state == ST_HOLD) holdCnt <= holdCnt + 1'b1;
      else                                          holdCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) backupSel <= 1'b0;
    else       backupSel <= (level == LVL_OFF);
  end

  assign ready             = (state == ST_RUN);
  assign writeProtect      = ~ready;
  assign strobe.accessEn   = ready;
  assign strobe.abortWrite = ~ready;

endmodule

// File: rtl/pfwp_datapath.sv
`timescale 1ns/1ps
module pfwp_datapath
  import pfwp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDriveEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic              wrOpen;
  logic [ADDR_W-1:0] wrAddrHeld;
  logic [DATA_W-1:0] wrDataHeld;
  logic              wrStrobe;
  logic              wrCommit;

  assign wrStrobe = ~ceN & ~weN;
  assign wrCommit = wrOpen & ~wrStrobe & strobe.accessEn;

  // Track an open write strobe; protection discards it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOpen     <= 1'b0;
      wrAddrHeld <= '0;
      wrDataHeld <= '0;
    end else if (strobe.abortWrite) begin
      wrOpen <= 1'b0;
    end else if (wrStrobe) begin
      wrOpen     <= 1'b1;
      wrAddrHeld <= addr;
      wrDataHeld <= wrData;
    end else begin
      wrOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wrCommit) memArray[wrAddrHeld] <= wrDataHeld;
  end

  assign rdDriveEn = strobe.accessEn & ~ceN & ~oeN & weN;
  assign rdData    = rdDriveEn ? memArray[addr] : '0;

endmodule

// File: rtl/pfwp_supervisor.sv
`timescale 1ns/1ps
module pfwp_supervisor
  import pfwp_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int DATA_W         = 8,
  parameter int RECOVER_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOkRaw,
  input  logic              supplyProtRaw,
  input  logic              supplySwitchRaw,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDriveEn,
  output logic              writeProtect,
  output logic              backupSel,
  output logic              ready
);

  dpStrobe_t strobe;

  pfwp_ctrl #(
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .SYNC_STAGES   (2)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .supplyOkRaw    (supplyOkRaw),
    .supplyProtRaw  (supplyProtRaw),
    .supplySwitchRaw(supplySwitchRaw),
    .strobe         (strobe),
    .writeProtect   (writeProtect),
    .backupSel      (backupSel),
    .ready          (ready)
  );

  pfwp_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ceN      (ceN),
    .weN      (weN),
    .oeN      (oeN),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdDriveEn(rdDriveEn)
  );

endmodule

// File: rtl/pfwp_checker.sv
`timescale 1ns/1ps
module pfwp_checker (
  input logic clk,
  input logic rstN,
  input logic supplyOkRaw,
  input logic supplyProtRaw,
  input logic supplySwitchRaw,
  input logic ceN,
  input logic weN,
  input logic oeN,
  input logic rdDriveEn,
  input logic writeProtect,
  input logic backupSel,
  input logic ready
);

  assert_no_read_when_protected_R4: assert property (
    @(posedge clk) disable iff (!rstN) writeProtect |-> !rdDriveEn);

  assert_backup_implies_protect_R5: assert property (
    @(posedge clk) disable iff (!rstN) backupSel |-> writeProtect);

  assert_ready_protect_exclusive_R3: assert property (
    @(posedge clk) disable iff (!rstN) ready |-> !writeProtect);

  assert_drive_needs_read_strobe_R11: assert property (
    @(posedge clk) disable iff (!rstN) rdDriveEn |-> (!ceN && !oeN && weN));

  assert_ready_needs_full_supply_R7: assert property (
    @(posedge clk) disable iff (!rstN)
      $rose(ready) |-> ($past(supplyOkRaw, 3) && $past(supplyProtRaw, 3)
                        && $past(supplySwitchRaw, 3)));

endmodule

bind pfwp_supervisor pfwp_checker chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .supplyOkRaw    (supplyOkRaw),
  .supplyProtRaw  (supplyProtRaw),
  .supplySwitchRaw(supplySwitchRaw),
  .ceN            (ceN),
  .weN            (weN),
  .oeN            (oeN),
  .rdDriveEn      (rdDriveEn),
  .writeProtect   (writeProtect),
  .backupSel      (backupSel),
  .ready          (ready)
);

// File: tb/pfwp_supervisor_tb_top.sv
`timescale 1ns/1ps
module pfwp_supervisor_tb_top;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int NREC   = 40;

  logic clk = 1'b0;
  logic rstN;
  logic okRaw, protRaw, swRaw;
  logic ceN, weN, oeN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic rdDriveEn, writeProtect, backupSel, ready;

  int testsRun = 0;
  int failCnt  = 0;
  bit rdActive = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              en;
    string             req;
  } rdExp_t;
  rdExp_t expQ[$];

  always #2 clk = ~clk;

  pfwp_supervisor #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RECOVER_CYCLES(NREC)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .supplyOkRaw(okRaw), .supplyProtRaw(protRaw), .supplySwitchRaw(swRaw),
    .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdDriveEn(rdDriveEn),
    .writeProtect(writeProtect), .backupSel(backupSel), .ready(ready)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  // Driver: push expectation, open a read window for one cycle
  task automatic readExp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic en, input string req);
    rdExp_t item;
    item.data = d; item.en = en; item.req = req;
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    expQ.push_back(item);
    rdActive = 1'b1;
    @(negedge clk);
    rdActive = 1'b0;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  // Monitor: compare read bus against queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rdActive && expQ.size() > 0) begin
        rdExp_t item;
        item = expQ.pop_front();
        chk(item.req, "read drive enable", 32'(rdDriveEn), 32'(item.en));
        if (item.en) chk(item.req, "read data", 32'(rdData), 32'(item.data));
      end
    end
  end

  task automatic exactRecovery(input string req);
    repeat (NREC + 2) @(posedge clk);
    #1 chk(req, "ready before hold-off ends", 32'(ready), 32'd0);
    @(posedge clk);
    #1 chk(req, "ready at hold-off end", 32'(ready), 32'd1);
  endtask

  initial begin
    rstN = 1'b0; okRaw = 1'b1; protRaw = 1'b1; swRaw = 1'b1;
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; wrData = '0;
    settle(3);
    chk("R1", "writeProtect in reset", 32'(writeProtect), 32'd1);
    chk("R1", "ready in reset", 32'(ready), 32'd0);
    chk("R1", "backupSel in reset", 32'(backupSel), 32'd0);
    chk("R1", "rdDriveEn in reset", 32'(rdDriveEn), 32'd0);

    // Power-up from reset, exact hold-off
    rstN = 1'b1;
    exactRecovery("R7");
    settle(1);
    chk("R7", "writeProtect after recovery", 32'(writeProtect), 32'd0);
    chk("R5", "backupSel at full supply", 32'(backupSel), 32'd0);

    // Normal read/write, edge addresses
    writeByte(13'h0000, 8'hA5);
    writeByte(13'h1FFF, 8'h3C);
    writeByte(13'h0123, 8'h5A);
    writeByte(13'h1000, 8'hC3);
    readExp(13'h0000, 8'hA5, 1'b1, "R9");
    readExp(13'h1FFF, 8'h3C, 1'b1, "R9");
    readExp(13'h0123, 8'h5A, 1'b1, "R9");
    readExp(13'h1000, 8'hC3, 1'b1, "R9");

    // Write strobe releases the read bus; oeN high releases it too
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; addr = 13'h0000; wrData = 8'hA5;
    @(posedge clk); #1 chk("R11", "drive during write strobe", 32'(rdDriveEn), 32'd0);
    @(negedge clk); weN = 1'b1; oeN = 1'b1;
    @(posedge clk); #1 chk("R11", "drive with oeN high", 32'(rdDriveEn), 32'd0);
    @(negedge clk); ceN = 1'b1;
    settle(1);

    // Falling into the hysteresis band keeps access
    okRaw = 1'b0;
    settle(6);
    chk("R6", "writeProtect in band going down", 32'(writeProtect), 32'd0);
    chk("R6", "ready in band going down", 32'(ready), 32'd1);
    readExp(13'h0123, 8'h5A, 1'b1, "R6");

    // Below protect level, with exact synchronizer latency
    @(negedge clk); protRaw = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R2", "protect after two edges", 32'(writeProtect), 32'd0);
    @(posedge clk);
    #1 chk("R2", "protect after three edges", 32'(writeProtect), 32'd1);
    settle(3);
    chk("R3", "writeProtect below protect level", 32'(writeProtect), 32'd1);
    chk("R3", "ready below protect level", 32'(ready), 32'd0);
    chk("R5", "backupSel above switchover", 32'(backupSel), 32'd0);

    // Accesses ignored while protected
    writeByte(13'h0000, 8'hFF);
    readExp(13'h0000, 8'h00, 1'b0, "R4");

    // Backup switchover and return
    swRaw = 1'b0;
    settle(6);
    chk("R5", "backupSel below switchover", 32'(backupSel), 32'd1);
    swRaw = 1'b1;
    settle(6);
    chk("R5", "backupSel back above switchover", 32'(backupSel), 32'd0);
    chk("R5", "still protected above switchover", 32'(writeProtect), 32'd1);

    // Rising into band keeps protection
    protRaw = 1'b1;
    settle(20);
    chk("R6", "protected in band going up", 32'(writeProtect), 32'd1);
    chk("R6", "not ready in band going up", 32'(ready), 32'd0);

    // Hold-off restart
    @(negedge clk); okRaw = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk); okRaw = 1'b0;
    settle(4);
    chk("R7", "ready during dropout", 32'(ready), 32'd0);
    @(negedge clk); okRaw = 1'b1;
    exactRecovery("R7");
    settle(1);

    // Contents preserved, protected write had no effect
    readExp(13'h0000, 8'hA5, 1'b1, "R4");
    readExp(13'h1FFF, 8'h3C, 1'b1, "R9");

    // Open write strobe caught by protection
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = 13'h1000; wrData = 8'h11;
    settle(1);
    protRaw = 1'b0;
    settle(6);
    chk("R10", "protected under open strobe", 32'(writeProtect), 32'd1);
    ceN = 1'b1; weN = 1'b1;
    settle(2);
    protRaw = 1'b1;
    settle(NREC + 10);
    chk("R10", "ready after recovery", 32'(ready), 32'd1);
    readExp(13'h1000, 8'hC3, 1'b1, "R10");

    // Inconsistent flag combinations
    protRaw = 1'b0;
    settle(6);
    chk("R8", "full without protect reads low", 32'(writeProtect), 32'd1);
    chk("R8", "no backup for that combination", 32'(backupSel), 32'd0);
    protRaw = 1'b1; swRaw = 1'b0;
    settle(6);
    chk("R8", "switch low reads off", 32'(backupSel), 32'd1);
    chk("R8", "protected when read off", 32'(writeProtect), 32'd1);
    swRaw = 1'b1;
    settle(NREC + 10);
    chk("R9", "ready after full sequence", 32'(ready), 32'd1);
    readExp(13'h0123, 8'h5A, 1'b1, "R9");
    readExp(13'h0000, 8'hA5, 1'b1, "R9");

    settle(4);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  end

endmodule